// File: doc/BRIEF.md
# Codec Event Flag Interrupt Unit

This unit collects six single-cycle event pulses from an audio codec (jack change, output short circuit, headphone ramp-up finished, headphone ramp-down finished, digital gain-up finished, digital gain-down finished). It latches each pulse into a sticky flag and raises one interrupt line. Software reads a flag register, acknowledges events by writing ones to the matching bits, and uses a mask register to block individual events. The same mask register also picks the electrical form of the interrupt line.

Besides the latched events, the flag register shows the present level of the jack-detect input. This bit follows the input directly and is never latched or cleared. Both registers are always visible on parallel read ports. Writes arrive as a one-cycle strobe with a select and an 8-bit data word.

Top module: `codec_evt_irq`

## Requirements
- R1: After reset the flag register reads 0 in bits 5:0, the mask register reads 0x3F (all six events masked, form field 00), and the interrupt output is low.
- R2: A pulse on event input k (bit order: 5 jack change, 4 short circuit, 3 ramp-up done, 2 ramp-down done, 1 gain-up done, 0 gain-down done) sets flag bit k at the next clock edge. The bit stays set after the pulse ends.
- R3: A write to the flag register (select = 1) clears each flag bit 5:0 whose data bit is 1 and leaves the bits whose data bit is 0 unchanged.
- R4: Flag bit 6 always equals the jack level input, and a flag write does not change it. Flag bit 7 always reads 0.
- R5: When an event pulse and a write-one clear hit the same flag in the same cycle, the flag is set after that edge.
- R6: A write to the mask register (select = 0) stores all 8 data bits, and they read back unchanged. A set bit k in 5:0 masks event k.
- R7: With form 00 in mask bits 7:6, the interrupt output is high exactly when some flag bit k is set while mask bit k is clear.
- R8: With form 01 the interrupt output is the inverse of the R7 condition (active low).
- R9: With form 10 the interrupt output is high for one cycle each time a flag bit becomes set-and-unmasked, whether a new event or an unmask causes it. At all other times it is low.
- R10: Form 11 behaves exactly like form 00.
- R11: A flag write leaves the mask register unchanged, and a mask write leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 6 | Event pulses, one bit per event |
| jack_lvl_i | input | 1 | Live jack presence level |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 mask register, 1 flag register |
| wr_data_i | input | 8 | Write data |
| mask_rd_o | output | 8 | Mask register read value |
| flag_rd_o | output | 8 | Flag register read value |
| irq_o | output | 1 | Interrupt output in the selected form |

## Verification
All 64 event patterns are applied to cleared flags, which separates the bit positions from one another and shows that the flags are sticky. Every write-clear pattern is then applied to a fully set register to confirm that only the one bits clear. For each level form, all 64 mask values are crossed with several flag patterns, so a wrong bit pairing between mask and flag, a swapped polarity, or a 11 form decoded as low level gives a different interrupt value. Directed sequences test the pulse form: a new event, an event that is already latched, and an unmask of a latched flag each have a distinct expected pulse. The same-cycle set-and-clear collision, jack toggling, and cross-register write isolation are also tested.

// File: rtl/evirq_pkg.sv
package evirq_pkg;

    localparam int EVT_N    = 6;
    localparam int REG_W    = 8;
    localparam int FORM_W   = 2;
    localparam int JACK_POS = EVT_N;

    typedef enum logic [FORM_W-1:0] {
        FORM_LVL_HI = 2'b00,
        FORM_LVL_LO = 2'b01,
        FORM_PULSE  = 2'b10,
        FORM_ALIAS  = 2'b11
    } irq_form_e;

    typedef struct packed {
        logic [FORM_W-1:0] form;
        logic [EVT_N-1:0]  hide;
    } mask_reg_t;

    localparam logic WSEL_MASK = 1'b0;
    localparam logic WSEL_FLAG = 1'b1;

    localparam mask_reg_t MASK_RESET = '{form: FORM_LVL_HI, hide: {EVT_N{1'b1}}};

    function automatic irq_form_e norm_form(input logic [FORM_W-1:0] raw);
        irq_form_e f;
        case (raw)
            2'b01:   f = FORM_LVL_LO;
            2'b10:   f = FORM_PULSE;
            default: f = FORM_LVL_HI;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/evirq_flags.sv
module evirq_flags
    import evirq_pkg::*;
#(
    parameter int N = EVT_N,
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         live_i,
    output logic [N-1:0] flag_o,
    output logic [W-1:0] rd_o
);
    localparam int PAD = W - N - 1;

    logic [N-1:0] flag_q;

    for (genvar k = 0; k < N; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                flag_q[k] <= 1'b0;
            else if (set_i[k])
                flag_q[k] <= 1'b1;
            else if (clr_i[k])
                flag_q[k] <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign rd_o   = {{PAD{1'b0}}, live_i, flag_q};

endmodule

// File: rtl/evirq_mask.sv
module evirq_mask
    import evirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    output mask_reg_t        mask_o
);
    mask_reg_t mask_q;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= MASK_RESET;
        else if (we_i)
            mask_q <= mask_reg_t'(wdata_i);
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/evirq_out.sv
module evirq_out
    import evirq_pkg::*;
#(
    parameter int N = EVT_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      flag_i,
    input  logic [N-1:0]      hide_i,
    input  logic [FORM_W-1:0] form_i,
    output logic              irq_o
);
    logic [N-1:0] pend;
    logic [N-1:0] pend_prev_q;
    logic         any_pend;
    logic         fresh;
    irq_form_e    form;

    assign pend     = flag_i & ~hide_i;
    assign any_pend = |pend;
    assign fresh    = |(pend & ~pend_prev_q);
    assign form     = norm_form(form_i);

    always_ff @(posedge clk) begin
        if (rst)
            pend_prev_q <= '0;
        else
            pend_prev_q <= pend;
    end

    always_comb begin
        unique case (form)
            FORM_LVL_LO: irq_o = ~any_pend;
            FORM_PULSE:  irq_o = fresh;
            default:     irq_o = any_pend;
        endcase
    end

endmodule

// File: rtl/codec_evt_irq.sv
module codec_evt_irq
    import evirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_N-1:0] evt_i,
    input  logic             jack_lvl_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] mask_rd_o,
    output logic [REG_W-1:0] flag_rd_o,
    output logic             irq_o
);
    logic             flag_we;
    logic             mask_we;
    logic [EVT_N-1:0] clr_vec;
    logic [EVT_N-1:0] flags;
    mask_reg_t        mask;

    assign flag_we = wr_en_i && (wr_sel_i == WSEL_FLAG);
    assign mask_we = wr_en_i && (wr_sel_i == WSEL_MASK);
    assign clr_vec = flag_we ? wr_data_i[EVT_N-1:0] : '0;

    evirq_flags #(.N(EVT_N), .W(REG_W)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (evt_i),
        .clr_i  (clr_vec),
        .live_i (jack_lvl_i),
        .flag_o (flags),
        .rd_o   (flag_rd_o)
    );

    evirq_mask u_mask (
        .clk     (clk),
        .rst     (rst),
        .we_i    (mask_we),
        .wdata_i (wr_data_i),
        .mask_o  (mask)
    );

    evirq_out #(.N(EVT_N)) u_out (
        .clk    (clk),
        .rst    (rst),
        .flag_i (flags),
        .hide_i (mask.hide),
        .form_i (mask.form),
        .irq_o  (irq_o)
    );

    assign mask_rd_o = REG_W'(mask);

endmodule

// File: rtl/codec_evt_irq_chk.sv
module codec_evt_irq_chk
    import evirq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [EVT_N-1:0] evt_i,
    input logic             jack_lvl_i,
    input logic             wr_en_i,
    input logic             wr_sel_i,
    input logic [REG_W-1:0] wr_data_i,
    input logic [REG_W-1:0] mask_rd_o,
    input logic [REG_W-1:0] flag_rd_o,
    input logic             irq_o
);
    logic flag_wr;
    logic mask_wr;
    assign flag_wr = wr_en_i && wr_sel_i;
    assign mask_wr = wr_en_i && !wr_sel_i;

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        (evt_i != '0) |=> ((flag_rd_o[EVT_N-1:0] & $past(evt_i)) == $past(evt_i))); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !flag_wr |=> (($past(flag_rd_o[EVT_N-1:0]) & ~flag_rd_o[EVT_N-1:0]) == '0)); // R3

    AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
        flag_rd_o[REG_W-1] == 1'b0); // R4

    AST_JACK_LIVE: assert property (@(posedge clk) disable iff (rst)
        flag_rd_o[JACK_POS] == jack_lvl_i); // R4

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> $stable(mask_rd_o)); // R11

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> (mask_rd_o == $past(wr_data_i))); // R6

    AST_LEVEL_HI: assert property (@(posedge clk) disable iff (rst)
        (mask_rd_o[7:6] == 2'b00) |->
            (irq_o == |(flag_rd_o[EVT_N-1:0] & ~mask_rd_o[EVT_N-1:0]))); // R7

    AST_LEVEL_LO: assert property (@(posedge clk) disable iff (rst)
        (mask_rd_o[7:6] == 2'b01) |->
            (irq_o == !(|(flag_rd_o[EVT_N-1:0] & ~mask_rd_o[EVT_N-1:0])))); // R8

    AST_PULSE_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        ((mask_rd_o[7:6] == 2'b10) && irq_o) |->
            ((flag_rd_o[EVT_N-1:0] & ~mask_rd_o[EVT_N-1:0]) != '0)); // R9

endmodule

bind codec_evt_irq codec_evt_irq_chk u_chk (.*);

// File: tb/tb_codec_evt_irq.sv
module tb_codec_evt_irq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] evt_i;
    logic       jack_lvl_i;
    logic       wr_en_i;
    logic       wr_sel_i;
    logic [7:0] wr_data_i;
    logic [7:0] mask_rd_o;
    logic [7:0] flag_rd_o;
    logic       irq_o;

    int vecs  = 0;
    int fails = 0;
    bit done  = 0;

    codec_evt_irq dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, wait through posedge, return at next negedge idle
    task automatic step(input logic [5:0] e, input logic we, input logic sel, input logic [7:0] d);
        evt_i = e; wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
        @(posedge clk);
        @(negedge clk);
        evt_i = '0; wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic wr_mask(input logic [7:0] d); step(6'h0, 1'b1, 1'b0, d); endtask
    task automatic wr_flag(input logic [7:0] d); step(6'h0, 1'b1, 1'b1, d); endtask
    task automatic idle(); step(6'h0, 1'b0, 1'b0, 8'h0); endtask

    function automatic logic lvl(input logic [5:0] f, input logic [5:0] m);
        return |(f & ~m);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; evt_i = '0; jack_lvl_i = 1'b0;
        wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 flags", flag_rd_o, 8'h00);
        chk("R1 mask", mask_rd_o, 8'h3F);
        chk("R1 irq", {7'h0, irq_o}, 8'h00);

        // R2 every event pattern on cleared flags, sticky after pulse
        for (int p = 0; p < 64; p++) begin
            wr_flag(8'h3F);
            step(6'(p), 1'b0, 1'b0, 8'h0);
            chk("R2 set", flag_rd_o, 8'(p));
            idle();
            chk("R2 sticky", flag_rd_o, 8'(p));
        end

        // R3 every clear pattern on a full register; bits 7:6 of data harmless
        for (int c = 0; c < 64; c++) begin
            step(6'h3F, 1'b0, 1'b0, 8'h0);
            wr_flag(8'(c) | 8'hC0);
            chk("R3 w1c", flag_rd_o, 8'(6'h3F & ~6'(c)));
        end

        // R4 jack is live and not clearable
        wr_flag(8'h3F);
        jack_lvl_i = 1'b1; #1;
        chk("R4 jack high", flag_rd_o, 8'h40);
        wr_flag(8'hFF);
        chk("R4 jack after write", flag_rd_o, 8'h40);
        jack_lvl_i = 1'b0; #1;
        chk("R4 jack low", flag_rd_o, 8'h00);

        // R5 set and clear collide
        step(6'h0C, 1'b0, 1'b0, 8'h0);
        step(6'h04, 1'b1, 1'b1, 8'h0C);
        chk("R5 collision", flag_rd_o, 8'h04);

        // R6 / R11 mask load and isolation
        wr_flag(8'h3F);
        step(6'h15, 1'b0, 1'b0, 8'h0);
        wr_mask(8'hA5);
        chk("R6 mask readback", mask_rd_o, 8'hA5);
        chk("R11 flags kept on mask write", flag_rd_o, 8'h15);
        wr_flag(8'h01);
        chk("R11 mask kept on flag write", mask_rd_o, 8'hA5);
        chk("R3 partial clear", flag_rd_o, 8'h14);

        // R7 / R8 / R10 mask sweep over level forms
        for (int fp = 0; fp < 4; fp++) begin
            logic [5:0] pat;
            pat = (fp == 0) ? 6'h01 : (fp == 1) ? 6'h20 : (fp == 2) ? 6'h2A : 6'h3F;
            wr_mask(8'h3F);
            wr_flag(8'h3F);
            step(pat, 1'b0, 1'b0, 8'h0);
            for (int m = 0; m < 64; m++) begin
                wr_mask({2'b00, 6'(m)});
                chk("R7 high level", {7'h0, irq_o}, {7'h0, lvl(pat, 6'(m))});
                wr_mask({2'b01, 6'(m)});
                chk("R8 low level", {7'h0, irq_o}, {7'h0, ~lvl(pat, 6'(m))});
                wr_mask({2'b11, 6'(m)});
                chk("R10 alias", {7'h0, irq_o}, {7'h0, lvl(pat, 6'(m))});
            end
        end

        // R9 pulse form
        wr_mask(8'h80);
        wr_flag(8'h3F);
        idle();
        chk("R9 quiet", {7'h0, irq_o}, 8'h00);
        step(6'h08, 1'b0, 1'b0, 8'h0);
        chk("R9 pulse on event", {7'h0, irq_o}, 8'h01);
        idle();
        chk("R9 pulse ends", {7'h0, irq_o}, 8'h00);
        step(6'h08, 1'b0, 1'b0, 8'h0);
        chk("R9 repeat event no pulse", {7'h0, irq_o}, 8'h00);
        step(6'h02, 1'b0, 1'b0, 8'h0);
        chk("R9 second bit pulses", {7'h0, irq_o}, 8'h01);
        idle();
        chk("R9 second pulse ends", {7'h0, irq_o}, 8'h00);
        wr_mask(8'h81);
        step(6'h01, 1'b0, 1'b0, 8'h0);
        chk("R9 masked event no pulse", {7'h0, irq_o}, 8'h00);
        wr_mask(8'h80);
        chk("R9 unmask pulse", {7'h0, irq_o}, 8'h01);
        idle();
        chk("R9 unmask pulse ends", {7'h0, irq_o}, 8'h00);
        chk("R2 flags in pulse form", flag_rd_o, 8'h0B);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule